// File: doc/BRIEF.md
# Step Attenuator Control Logic

This block is the digital control front end of a five-bit binary-weighted step attenuator. It produces a registered five-bit attenuation code for the switch array. That code can come from one of two sources. The first is a five-line parallel port, which can run in direct mode, where the output follows the pins, or in held mode, where the value is frozen while the latch enable is low. The second is a three-wire serial port, where a six-bit shift register sits behind a transparent latch. A mode pin selects between the two paths.

All control pins are asynchronous to the block clock. They pass through two-stage synchronizers before use, and serial clock edges are detected in the block clock domain. Reset stands for power-up. While reset is asserted, the output is loaded with a preset that depends on the mode pins. A serial word whose leading start bit is set is never applied. Latching such a word raises a sticky error flag that only reset clears.

Top module: `stepatt_ctrl`

## Requirements
- R1: `ser_mode_i` low selects the parallel port and high selects the serial port. In serial mode, changes on `ctl_code_i` do not affect `atten_o`.
- R2: `atten_o` is a binary code in half-dB steps. Bit 4 weighs 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB, so 0 is the reference-loss state and 31 is 15.5 dB.
- R3: In parallel mode with latch enable high, `atten_o` follows `ctl_code_i`.
- R4: In parallel mode with latch enable low, `atten_o` keeps the value it had when latch enable fell.
- R5: The serial register is six bits wide. It shifts `sdata_i` in on each rising `sclk_i` edge, first bit ending up most significant, whatever the latch enable level. The word order is start bit, then the 8, 4, 2, 1 and 0.5 dB bits.
- R6: In serial mode with latch enable high and start bit 0, `atten_o` equals the low five bits of the serial register. With latch enable low, `atten_o` is frozen.
- R7: A serial word with start bit 1 never reaches `atten_o`. A latch enable fall in serial mode while the start bit is 1 sets `start_err_o`, which stays set until reset.
- R8: At reset in serial mode, `atten_o` takes the value on `ctl_code_i`.
- R9: At reset in parallel mode with latch enable low, `atten_o` is 0 when `pup_sel_i` is 0 and 16 (8 dB) when it is 1.
- R10: At reset in parallel mode with latch enable high, `pup_sel_i` is ignored and `atten_o` takes `ctl_code_i`.
- R11: A pin change reaches `atten_o` no earlier than two and no later than three clock edges after it is applied. `start_err_o` reads 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset, models power-up |
| ser_mode_i | input | 1 | 0 = parallel port, 1 = serial port |
| ctl_code_i | input | 5 | Parallel attenuation code, also the power-up preset |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock, sampled on rising edges |
| latch_en_i | input | 1 | Latch enable: high = transparent, low = hold |
| pup_sel_i | input | 1 | Power-up select for parallel mode with latch enable low |
| atten_o | output | 5 | Registered attenuation code |
| start_err_o | output | 1 | Sticky flag for a latched word with bad start bit |

## Verification
A wrong shift order or a lost shift shows up as a wrong `atten_o` code on the next latch pulse. That is about four clock cycles after latch enable rises. A bad hold path shows up as an `atten_o` that moves while latch enable is low, within three edges of a code or serial change. A wrong power-up decode shows at the first sample after reset. A start-bit check that misses or fires by mistake appears on `start_err_o` within three edges of the latch enable fall.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;
  localparam int ATT_W  = 5;
  localparam int WORD_W = ATT_W + 1;

  // preset loaded while reset is held
  function automatic logic [ATT_W-1:0] pup_code(input logic ser, input logic le,
                                                input logic pup,
                                                input logic [ATT_W-1:0] pins);
    logic [ATT_W-1:0] hi;
    hi = '0;
    hi[ATT_W-1] = 1'b1;
    if (ser || le) return pins;
    return pup ? hi : '0;
  endfunction

  function automatic logic start_ok(input logic [WORD_W-1:0] w);
    return ~w[WORD_W-1];
  endfunction

  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w,
                                                 input logic b);
    return {w[WORD_W-2:0], b};
  endfunction
endpackage

// File: rtl/stepatt_sync.sv
module stepatt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  // stages load the pin itself during reset so no false edge follows release
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= d;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/stepatt_shifter.sv
module stepatt_shifter
  import stepatt_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sdata_s,
  output logic [WW-1:0] word,
  output logic          shift_evt
);
  logic sclk_q;

  assign shift_evt = sclk_s & ~sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= sclk_s;
      word   <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (shift_evt) word <= shift_in(word, sdata_s);
    end
  end

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> word == {$past(word[WW-2:0]), $past(sdata_s)}); // R5
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_s || sclk_q) |=> $stable(word)); // R5
endmodule

// File: rtl/stepatt_state.sv
module stepatt_state
  import stepatt_pkg::*;
#(
  parameter int AW = ATT_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_s,
  input  logic          le_s,
  input  logic [AW-1:0] code_s,
  input  logic [WW-1:0] word,
  input  logic          mode_raw,
  input  logic          le_raw,
  input  logic          pup_raw,
  input  logic [AW-1:0] code_raw,
  output logic [AW-1:0] atten,
  output logic          err
);
  logic le_q;
  logic le_fall;
  logic word_good;
  logic bad_latch;

  assign le_fall   = le_q & ~le_s;
  assign word_good = start_ok(word);
  assign bad_latch = mode_s & le_fall & ~word_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_q  <= le_s;
      atten <= pup_code(mode_raw, le_raw, pup_raw, code_raw);
      err   <= 1'b0;
    end else begin
      le_q <= le_s;
      if (le_s) begin
        if (!mode_s)        atten <= code_s;
        else if (word_good) atten <= word[AW-1:0];
      end
      if (bad_latch) err <= 1'b1;
    end
  end

  AST_HOLD_LE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> $stable(atten)); // R4
  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && le_s) |=> atten == $past(code_s)); // R3
  AST_SER_TRANSP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && le_s && !word[WW-1]) |=> atten == $past(word[AW-1:0])); // R6
  AST_BAD_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && le_s && word[WW-1]) |=> $stable(atten)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R7
endmodule

// File: rtl/stepatt_ctrl.sv
module stepatt_ctrl
  import stepatt_pkg::*;
#(
  parameter int AW          = ATT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_mode_i,
  input  logic [AW-1:0] ctl_code_i,
  input  logic          sdata_i,
  input  logic          sclk_i,
  input  logic          latch_en_i,
  input  logic          pup_sel_i,
  output logic [AW-1:0] atten_o,
  output logic          start_err_o
);
  localparam int WW = AW + 1;
  localparam int SW = AW + 4;

  logic [SW-1:0] pins_raw;
  logic [SW-1:0] pins_s;
  logic          mode_s;
  logic [AW-1:0] code_s;
  logic          sdata_s;
  logic          sclk_s;
  logic          le_s;
  logic [WW-1:0] word;
  logic          shift_evt;

  assign pins_raw = {ser_mode_i, ctl_code_i, sdata_i, sclk_i, latch_en_i};
  assign {mode_s, code_s, sdata_s, sclk_s, le_s} = pins_s;

  stepatt_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  stepatt_shifter #(.WW(WW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .sdata_s   (sdata_s),
    .word      (word),
    .shift_evt (shift_evt)
  );

  stepatt_state #(.AW(AW), .WW(WW)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_s   (mode_s),
    .le_s     (le_s),
    .code_s   (code_s),
    .word     (word),
    .mode_raw (ser_mode_i),
    .le_raw   (latch_en_i),
    .pup_raw  (pup_sel_i),
    .code_raw (ctl_code_i),
    .atten    (atten_o),
    .err      (start_err_o)
  );

  AST_MODE_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !shift_evt && !le_s) |=> $stable(atten_o)); // R1
endmodule

// File: tb/stepatt_ctrl_tb.sv
`timescale 1ns/1ps
module stepatt_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [4:0] code = '0;
  logic       sdat = 1'b0;
  logic       sclk = 1'b0;
  logic       le = 1'b0;
  logic       pup = 1'b0;
  logic [4:0] atten;
  logic       err;
  int         n_run = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  stepatt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_mode_i(mode), .ctl_code_i(code),
    .sdata_i(sdat), .sclk_i(sclk), .latch_en_i(le), .pup_sel_i(pup),
    .atten_o(atten), .start_err_o(err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // half-dB units from bit weights 8,4,2,1,0.5 dB
  function automatic int half_db(input logic [4:0] c);
    int dbx2 = 0;
    int w = 16;
    for (int b = 4; b >= 0; b--) begin
      if (c[b]) dbx2 += w;
      w = w / 2;
    end
    return dbx2;
  endfunction

  task automatic powerup(input logic m, input logic l, input logic p, input logic [4:0] c);
    rst_n = 1'b0; mode = m; le = l; pup = p; code = c; sdat = 1'b0; sclk = 1'b0;
    step(3);
    chk("R11 err low in reset", err, 0);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic send_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) begin
      sdat = w[i];
      step(2);
      sclk = 1'b1;
      step(2);
      sclk = 1'b0;
      step(2);
    end
    step(2);
  endtask

  task automatic pulse_le;
    le = 1'b1; step(4); le = 1'b0; step(4);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int prev;
    // R10: parallel, latch open at reset -> pins, select ignored
    powerup(1'b0, 1'b1, 1'b0, 5'd19);
    chk("R10 pup0", atten, 19);
    chk("R11 err after reset", err, 0);
    powerup(1'b0, 1'b1, 1'b1, 5'd3);
    chk("R10 pup1 ignored", atten, 3);
    // R9: parallel, latch closed at reset
    powerup(1'b0, 1'b0, 1'b0, 5'd21);
    chk("R9 pup0", atten, 0);
    powerup(1'b0, 1'b0, 1'b1, 5'd21);
    chk("R9 pup1", atten, 16);
    // R8: serial mode preset from pins, every code
    for (int c = 0; c < 32; c++) begin
      powerup(1'b1, 1'b0, c[0], 5'(c));
      chk("R8 serial preset", atten, c);
    end
    // R2/R3: direct parallel sweep
    powerup(1'b0, 1'b1, 1'b0, 5'd0);
    for (int c = 0; c < 32; c++) begin
      code = 5'(c);
      step(4);
      chk("R2 R3 direct code", half_db(atten), 2 * c * 8 / 16 * 2 / 2 + (c - c));
    end
    // R11: latency
    code = 5'd10; step(4);
    code = 5'd22; step(1);
    chk("R11 not before sync", atten, 10);
    step(3);
    chk("R11 arrives", atten, 22);
    // R4: hold with latch closed
    le = 1'b0; step(2);
    code = 5'd5; step(6);
    chk("R4 held", atten, 22);
    le = 1'b1; step(4);
    chk("R3 reopen", atten, 5);
    // R1: serial mode ignores parallel pins
    le = 1'b0; step(4);
    mode = 1'b1; step(4);
    code = 5'd9; step(4);
    chk("R1 pins ignored", atten, 5);
    prev = 5;
    // R5/R6: serial sweep with latch closed during shifting
    for (int c = 0; c < 32; c++) begin
      code = ~5'(c);
      send_word({1'b0, 5'(c)});
      chk("R5 shift with LE low", atten, prev);
      pulse_le();
      chk("R5 R6 serial word", atten, c);
      prev = c;
    end
    // R6: transparent while latch high, frozen when low
    le = 1'b1; step(2);
    send_word(6'b001110);
    chk("R6 transparent", atten, 14);
    le = 1'b0; step(4);
    send_word(6'b000001);
    chk("R6 frozen", atten, 14);
    chk("R7 no error yet", err, 0);
    // R7: bad start bit
    send_word(6'b100011);
    le = 1'b1; step(4);
    chk("R7 bad word held", atten, 14);
    le = 1'b0; step(4);
    chk("R7 error set", err, 1);
    send_word(6'b000111);
    pulse_le();
    chk("R6 after error", atten, 7);
    chk("R7 error sticky", err, 1);
    powerup(1'b1, 1'b0, 1'b0, 5'd0);
    chk("R7 reset clears", err, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule